// File: doc/BRIEF.md
# Single-wire bus master slot engine

This block turns one command at a time into the timed open-drain waveforms of a single-wire bus master. It can issue a bus reset with a presence check, a write-1 slot, a write-0 slot, a read slot, a whole-byte write and a whole-byte read. The byte operations are built from the same slots, least significant bit first. An internal microsecond tick comes from a clock-cycles-per-microsecond parameter. A run-time integer coefficient multiplies every delay, so a slow bus can be served without rebuilding.

A requester presents a command code with a start pulse while the engine is idle. The engine raises busy, runs the waveform and pulses done for one clock at the end. At that point the read data or the presence result is valid on its output. The block never drives the bus high. It only asserts a drive-low request, which the pad turns into an open-drain pull. The returning line level comes in on a sampled input.

A one-shot strong-pullup request can be armed beforehand. If the pullup is enabled, the next byte write switches the strong-pullup output on as its eighth slot begins and switches it off when that byte ends. The request is then consumed, whether or not the pullup was enabled.

Top module: `onewire_slot_engine`

## Requirements
- R1: Command code 0 (reset) drives the bus low for 480 us, releases it, samples the line 550 us after start and finishes 960 us after start. The presence output is the sampled level: 1 means no device answered and 0 means a device pulled the line low.
- R2: Command code 1 (write-1 slot) drives the bus low for 6 us and then releases it, finishing 70 us after start.
- R3: Command code 2 (write-0 slot) drives the bus low for 60 us and then releases it, finishing 70 us after start.
- R4: Command code 3 (read slot) drives the bus low for 6 us and samples the line 15 us after start. It finishes 70 us after start and returns the sampled bit on data output bit 0, with bits 7..1 zero.
- R5: Command code 4 (byte write) sends the data input as eight 70 us slots, least significant bit first. Each 1 bit is a 6 us low pulse and each 0 bit is a 60 us low pulse.
- R6: Command code 5 (byte read) runs eight read slots, and the bit sampled in slot i (counting from 0) appears on data output bit i at done.
- R7: Every delay is multiplied by the coefficient input, and a coefficient of 0 acts as 1.
- R8: When a strong-pullup request is pending and the pullup enable is high, a byte write raises the strong-pullup output as its eighth slot begins. It holds the output through that slot and drops it in the cycle done pulses. Every byte write clears the pending request, so a later byte write without a new request never raises the output.
- R9: The drive-low output is high only during the low phase of a slot, with exactly one low pulse per slot. At all other times the bus is released.
- R10: A start while busy is ignored, and so is a start with command code 6 or 7. Done is high for exactly one clock at the end of each operation, in the cycle busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse for the command on cmd |
| cmd | input | 3 | Command code (0 reset, 1 write-1, 2 write-0, 3 read bit, 4 write byte, 5 read byte) |
| dataIn | input | 8 | Byte to send for a byte write |
| coef | input | COEF_W | Delay multiplier (0 treated as 1) |
| pullupArm | input | 1 | Pulse that makes a strong-pullup request pending |
| pullupEn | input | 1 | Allows a pending request to drive the strong pullup |
| busIn | input | 1 | Sampled bus level, synchronous to clk |
| busy | output | 1 | An operation is running |
| done | output | 1 | One-clock pulse at the end of an operation |
| dataOut | output | 8 | Read result, updated at done |
| presence | output | 1 | Result of the last reset: 0 device present, 1 none |
| busDriveLow | output | 1 | Request to pull the bus low |
| strongPullup | output | 1 | Strong pullup enable |

## Verification
The checker assumes that busIn is already synchronous to the clock. It also assumes that start is a clean pulse, so that no command is accepted in the same cycle an operation ends. The bench drives start and cmd on falling edges for exactly one cycle. Its bus model derives busIn from busDriveLow and a device pull window that starts at a seen low edge. The device holds its pull for 30 us, which covers the 15 us read sample and ends well before the next slot. The presence pull covers the 550 us sample point and ends before the reset finishes.

// File: rtl/onewire_pkg.sv
package onewire_pkg;

  typedef enum logic [2:0] {
    CMD_RESET  = 3'd0,
    CMD_WR1    = 3'd1,
    CMD_WR0    = 3'd2,
    CMD_RDBIT  = 3'd3,
    CMD_WRBYTE = 3'd4,
    CMD_RDBYTE = 3'd5
  } cmd_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LOW,
    PH_MID,
    PH_TAIL
  } phase_e;

  typedef enum logic [1:0] {
    KIND_RST,
    KIND_ONE,
    KIND_ZERO
  } kind_e;

  localparam int BASE_W = 9;

  // Phase lengths in microseconds, before the coefficient is applied.
  localparam logic [BASE_W-1:0] RST_LOW_US  = 9'd480;
  localparam logic [BASE_W-1:0] RST_MID_US  = 9'd70;
  localparam logic [BASE_W-1:0] RST_TAIL_US = 9'd410;
  localparam logic [BASE_W-1:0] ONE_LOW_US  = 9'd6;
  localparam logic [BASE_W-1:0] ONE_MID_US  = 9'd9;
  localparam logic [BASE_W-1:0] ONE_TAIL_US = 9'd55;
  localparam logic [BASE_W-1:0] ZER_LOW_US  = 9'd60;
  localparam logic [BASE_W-1:0] ZER_MID_US  = 9'd5;
  localparam logic [BASE_W-1:0] ZER_TAIL_US = 9'd5;

  typedef struct packed {
    logic              load;
    logic [BASE_W-1:0] baseUs;
    logic              shiftRx;
    logic              latchPres;
    logic              commitByte;
    logic              commitBit;
    logic              loadTx;
    logic              shiftTx;
  } strobe_t;

endpackage

// File: rtl/onewire_datapath.sv
module onewire_datapath
  import onewire_pkg::*;
#(
  parameter int CLKS_PER_US = 200,
  parameter int COEF_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [COEF_W-1:0] coef,
  input  logic              busIn,
  input  logic [6:0]        dataInHi,
  output logic              txNext,
  output logic              expire,
  output logic [7:0]        dataOut,
  output logic              presence
);

  localparam int CYC_W = $clog2(CLKS_PER_US + 1);
  localparam int US_W  = BASE_W + COEF_W;
  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CLKS_PER_US - 1);

  logic [CYC_W-1:0]  cycCnt;
  logic [US_W-1:0]   usCnt;
  logic [US_W-1:0]   loadUs;
  logic [COEF_W-1:0] effCoef;
  logic              usTick;
  logic [6:0]        txReg;
  logic [7:0]        rxReg;

  assign effCoef = (coef == '0) ? COEF_W'(1) : coef;
  assign loadUs  = US_W'(stb.baseUs) * US_W'(effCoef);
  assign usTick  = (cycCnt == CYC_LAST);
  assign expire  = usTick && (usCnt == US_W'(1));
  assign txNext  = txReg[0];

  // Microsecond tick and phase down-counter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycCnt <= '0;
      usCnt  <= '0;
    end else if (stb.load) begin
      cycCnt <= '0;
      usCnt  <= loadUs;
    end else if (usTick) begin
      cycCnt <= '0;
      if (usCnt != '0) usCnt <= usCnt - US_W'(1);
    end else begin
      cycCnt <= cycCnt + CYC_W'(1);
    end
  end

  // Transmit bits 7..1; bit 0 goes straight from the port into the first slot.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txReg <= '0;
    else if (stb.loadTx) txReg <= dataInHi;
    else if (stb.shiftTx) txReg <= {1'b0, txReg[6:1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxReg <= '0;
    else if (stb.shiftRx) rxReg <= {busIn, rxReg[7:1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut  <= '0;
      presence <= 1'b1;
    end else begin
      if (stb.latchPres) presence <= busIn;
      if (stb.commitByte) dataOut <= rxReg;
      else if (stb.commitBit) dataOut <= {7'b0, rxReg[7]};
    end
  end

endmodule

// File: rtl/onewire_ctrl.sv
module onewire_ctrl
  import onewire_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [2:0] cmd,
  input  logic       dataIn0,
  input  logic       pullupArm,
  input  logic       pullupEn,
  input  logic       txNext,
  input  logic       expire,
  output strobe_t    stb,
  output logic       busy,
  output logic       done,
  output logic       busDriveLow,
  output logic       strongPullup
);

  phase_e     phase, phaseN;
  cmd_e       op, opN;
  kind_e      kind, kindN, firstKind;
  logic [2:0] bitIdx, bitN;
  logic       doneN, spuN, pendReg, pendN;
  logic       cmdValid, byteOp;

  function automatic logic [BASE_W-1:0] lowUs(kind_e k);
    case (k)
      KIND_RST:  return RST_LOW_US;
      KIND_ZERO: return ZER_LOW_US;
      default:   return ONE_LOW_US;
    endcase
  endfunction

  function automatic logic [BASE_W-1:0] midUs(kind_e k);
    case (k)
      KIND_RST:  return RST_MID_US;
      KIND_ZERO: return ZER_MID_US;
      default:   return ONE_MID_US;
    endcase
  endfunction

  function automatic logic [BASE_W-1:0] tailUs(kind_e k);
    case (k)
      KIND_RST:  return RST_TAIL_US;
      KIND_ZERO: return ZER_TAIL_US;
      default:   return ONE_TAIL_US;
    endcase
  endfunction

  assign cmdValid    = (cmd <= 3'd5);
  assign byteOp      = (op == CMD_WRBYTE) || (op == CMD_RDBYTE);
  assign busy        = (phase != PH_IDLE);
  assign busDriveLow = (phase == PH_LOW);

  always_comb begin
    case (cmd)
      3'd0:    firstKind = KIND_RST;
      3'd2:    firstKind = KIND_ZERO;
      3'd4:    firstKind = dataIn0 ? KIND_ONE : KIND_ZERO;
      default: firstKind = KIND_ONE;
    endcase
  end

  always_comb begin
    stb    = '0;
    phaseN = phase;
    opN    = op;
    kindN  = kind;
    bitN   = bitIdx;
    doneN  = 1'b0;
    spuN   = strongPullup;
    pendN  = pendReg | pullupArm;
    case (phase)
      PH_IDLE: begin
        if (start && cmdValid) begin
          opN        = cmd_e'(cmd);
          kindN      = firstKind;
          bitN       = 3'd0;
          stb.load   = 1'b1;
          stb.baseUs = lowUs(firstKind);
          stb.loadTx = (cmd == 3'd4);
          phaseN     = PH_LOW;
        end
      end
      PH_LOW: begin
        if (expire) begin
          stb.load   = 1'b1;
          stb.baseUs = midUs(kind);
          phaseN     = PH_MID;
        end
      end
      PH_MID: begin
        if (expire) begin
          stb.load      = 1'b1;
          stb.baseUs    = tailUs(kind);
          stb.latchPres = (op == CMD_RESET);
          stb.shiftRx   = (op == CMD_RDBIT) || (op == CMD_RDBYTE);
          phaseN        = PH_TAIL;
        end
      end
      default: begin
        if (expire) begin
          if (byteOp && (bitIdx != 3'd7)) begin
            bitN        = bitIdx + 3'd1;
            kindN       = (op == CMD_WRBYTE && !txNext) ? KIND_ZERO : KIND_ONE;
            stb.shiftTx = (op == CMD_WRBYTE);
            stb.load    = 1'b1;
            stb.baseUs  = lowUs(kindN);
            phaseN      = PH_LOW;
            if (op == CMD_WRBYTE && bitIdx == 3'd6 && pendReg && pullupEn)
              spuN = 1'b1;
          end else begin
            phaseN         = PH_IDLE;
            doneN          = 1'b1;
            stb.commitByte = (op == CMD_RDBYTE);
            stb.commitBit  = (op == CMD_RDBIT);
            if (op == CMD_WRBYTE) begin
              spuN  = 1'b0;
              pendN = 1'b0;
            end
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase        <= PH_IDLE;
      op           <= CMD_RESET;
      kind         <= KIND_RST;
      bitIdx       <= '0;
      done         <= 1'b0;
      strongPullup <= 1'b0;
      pendReg      <= 1'b0;
    end else begin
      phase        <= phaseN;
      op           <= opN;
      kind         <= kindN;
      bitIdx       <= bitN;
      done         <= doneN;
      strongPullup <= spuN;
      pendReg      <= pendN;
    end
  end

endmodule

// File: rtl/onewire_slot_engine.sv
module onewire_slot_engine
  import onewire_pkg::*;
#(
  parameter int CLKS_PER_US = 200,
  parameter int COEF_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        cmd,
  input  logic [7:0]        dataIn,
  input  logic [COEF_W-1:0] coef,
  input  logic              pullupArm,
  input  logic              pullupEn,
  input  logic              busIn,
  output logic              busy,
  output logic              done,
  output logic [7:0]        dataOut,
  output logic              presence,
  output logic              busDriveLow,
  output logic              strongPullup
);

  strobe_t stb;
  logic    txNext;
  logic    expire;

  onewire_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .cmd          (cmd),
    .dataIn0      (dataIn[0]),
    .pullupArm    (pullupArm),
    .pullupEn     (pullupEn),
    .txNext       (txNext),
    .expire       (expire),
    .stb          (stb),
    .busy         (busy),
    .done         (done),
    .busDriveLow  (busDriveLow),
    .strongPullup (strongPullup)
  );

  onewire_datapath #(
    .CLKS_PER_US (CLKS_PER_US),
    .COEF_W      (COEF_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .coef     (coef),
    .busIn    (busIn),
    .dataInHi (dataIn[7:1]),
    .txNext   (txNext),
    .expire   (expire),
    .dataOut  (dataOut),
    .presence (presence)
  );

endmodule

// File: rtl/onewire_checker.sv
module onewire_checker (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       done,
  input logic [7:0] dataOut,
  input logic       presence,
  input logic       busDriveLow,
  input logic       strongPullup
);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_busy_end_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  p_drive_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    busDriveLow |-> busy);

  p_spu_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    strongPullup |-> busy);

  p_spu_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strongPullup) |-> done);

  p_pres_busy_r1: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(presence) |-> busy);

  p_data_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dataOut) |-> done);

endmodule

bind onewire_slot_engine onewire_checker u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .busy         (busy),
  .done         (done),
  .dataOut      (dataOut),
  .presence     (presence),
  .busDriveLow  (busDriveLow),
  .strongPullup (strongPullup)
);

// File: tb/onewire_slot_engine_bench.sv
`timescale 1ns/1ps
module onewire_slot_engine_bench;

  localparam int CPU  = 2;
  localparam int SLOT = 70 * CPU;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [2:0] cmd = '0;
  logic [7:0] dataIn = '0;
  logic [3:0] coef = 4'd1;
  logic       pullupArm = 1'b0;
  logic       pullupEn = 1'b0;
  logic       busIn;
  logic       busy, done, presence, busDriveLow, strongPullup;
  logic [7:0] dataOut;

  always #2.5 clk = ~clk;

  onewire_slot_engine #(.CLKS_PER_US(CPU), .COEF_W(4)) u_onewire_slot_engine (
    .clk(clk), .rstN(rstN), .start(start), .cmd(cmd), .dataIn(dataIn),
    .coef(coef), .pullupArm(pullupArm), .pullupEn(pullupEn), .busIn(busIn),
    .busy(busy), .done(done), .dataOut(dataOut), .presence(presence),
    .busDriveLow(busDriveLow), .strongPullup(strongPullup)
  );

  int nChecks = 0;
  int nFails  = 0;

  // Bus and device model plus monitor.
  int         cyc = 0;
  int         startCyc = 0, doneCyc = 0, doneCount = 0;
  int         lens [0:255];
  int         nLow = 0, lowRun = 0;
  int         slotCnt = 0, slotBase = 0, sinceRose = 100000;
  int         spuRises = 0, spuSlot = 0, spuLen = 0;
  logic       prevDrive = 1'b0, prevSpu = 1'b0;
  logic       readMode = 1'b0, presMode = 1'b0;
  logic [7:0] pattern = '0;
  logic       slavePull;
  int         bitPos;

  assign bitPos    = slotCnt - slotBase - 1;
  assign slavePull = (readMode && bitPos >= 0 && bitPos < 8 && !pattern[bitPos[2:0]]
                      && sinceRose < 30 * CPU)
                   || (presMode && sinceRose >= 500 * CPU && sinceRose < 700 * CPU);
  assign busIn = !(busDriveLow || slavePull);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (start && !busy && rstN) startCyc <= cyc;
    if (done) begin doneCyc <= cyc; doneCount <= doneCount + 1; end
    prevDrive <= busDriveLow;
    prevSpu   <= strongPullup;
    if (busDriveLow && !prevDrive) begin
      slotCnt   <= slotCnt + 1;
      sinceRose <= 0;
    end else if (sinceRose < 100000) begin
      sinceRose <= sinceRose + 1;
    end
    if (busDriveLow) lowRun <= lowRun + 1;
    if (!busDriveLow && prevDrive) begin
      lens[nLow] <= lowRun;
      nLow       <= nLow + 1;
      lowRun     <= 0;
    end
    if (strongPullup && !prevSpu) begin
      spuRises <= spuRises + 1;
      spuSlot  <= slotCnt - slotBase;
      spuLen   <= 0;
    end
    if (strongPullup) spuLen <= spuLen + 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic runCmd(input logic [2:0] c, input logic [7:0] d, output int lowBase);
    int dc;
    @(negedge clk);
    lowBase  = nLow;
    slotBase = slotCnt;
    dc       = doneCount;
    cmd = c; dataIn = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (doneCount == dc) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic tResetState;
    check(!busy && !done && !busDriveLow && !strongPullup, "R9 reset idle", busy, 0);
    check(presence == 1'b1, "R1 reset presence", presence, 1);
  endtask

  task automatic tBusReset;
    int lb;
    presMode = 1'b1;
    runCmd(3'd0, 8'h00, lb);
    presMode = 1'b0;
    check(nLow - lb == 1, "R9 reset pulse count", nLow - lb, 1);
    check(lens[lb] == 480 * CPU, "R1 reset low width", lens[lb], 480 * CPU);
    check(doneCyc - startCyc == 960 * CPU + 1, "R1 reset length", doneCyc - startCyc, 960 * CPU + 1);
    check(presence == 1'b0, "R1 device present", presence, 0);
    runCmd(3'd0, 8'h00, lb);
    check(presence == 1'b1, "R1 no device", presence, 1);
  endtask

  task automatic tBitSlots;
    int lb;
    runCmd(3'd1, 8'h00, lb);
    check(lens[lb] == 6 * CPU, "R2 write-1 low", lens[lb], 6 * CPU);
    check(doneCyc - startCyc == SLOT + 1, "R2 write-1 length", doneCyc - startCyc, SLOT + 1);
    runCmd(3'd2, 8'h00, lb);
    check(lens[lb] == 60 * CPU, "R3 write-0 low", lens[lb], 60 * CPU);
    check(doneCyc - startCyc == SLOT + 1, "R3 write-0 length", doneCyc - startCyc, SLOT + 1);
  endtask

  task automatic tReadBit;
    int lb;
    readMode = 1'b1;
    pattern = 8'h00;
    runCmd(3'd3, 8'h00, lb);
    check(dataOut == 8'h00, "R4 read 0", dataOut, 0);
    check(lens[lb] == 6 * CPU, "R4 read low", lens[lb], 6 * CPU);
    pattern = 8'hFF;
    runCmd(3'd3, 8'h00, lb);
    check(dataOut == 8'h01, "R4 read 1", dataOut, 1);
    check(doneCyc - startCyc == SLOT + 1, "R4 read length", doneCyc - startCyc, SLOT + 1);
    readMode = 1'b0;
  endtask

  task automatic tWriteByte(input logic [7:0] v);
    int lb;
    runCmd(3'd4, v, lb);
    check(nLow - lb == 8, "R9 byte pulse count", nLow - lb, 8);
    for (int i = 0; i < 8; i++) begin
      int exp;
      exp = v[i] ? 6 * CPU : 60 * CPU;
      check(lens[lb + i] == exp, "R5 byte bit width", lens[lb + i], exp);
    end
    check(doneCyc - startCyc == 8 * SLOT + 1, "R5 byte length", doneCyc - startCyc, 8 * SLOT + 1);
  endtask

  task automatic tReadByte(input logic [7:0] v);
    int lb;
    readMode = 1'b1;
    pattern  = v;
    runCmd(3'd5, 8'h00, lb);
    readMode = 1'b0;
    check(dataOut == v, "R6 byte read", dataOut, v);
  endtask

  task automatic tCoef;
    int lb;
    coef = 4'd3;
    runCmd(3'd2, 8'h00, lb);
    check(lens[lb] == 180 * CPU, "R7 coef 3 low", lens[lb], 180 * CPU);
    check(doneCyc - startCyc == 3 * SLOT + 1, "R7 coef 3 length", doneCyc - startCyc, 3 * SLOT + 1);
    coef = 4'd0;
    runCmd(3'd1, 8'h00, lb);
    check(lens[lb] == 6 * CPU, "R7 coef 0 as 1", lens[lb], 6 * CPU);
    coef = 4'd1;
  endtask

  task automatic arm;
    @(negedge clk); pullupArm = 1'b1;
    @(negedge clk); pullupArm = 1'b0;
  endtask

  task automatic tPullup;
    int lb, r0;
    pullupEn = 1'b1;
    arm();
    r0 = spuRises;
    runCmd(3'd4, 8'hFF, lb);
    check(spuRises == r0 + 1, "R8 pullup raised", spuRises - r0, 1);
    check(spuSlot == 7, "R8 pullup at eighth slot", spuSlot, 7);
    check(spuLen == SLOT, "R8 pullup held one slot", spuLen, SLOT);
    check(strongPullup == 1'b0, "R8 pullup off after byte", strongPullup, 0);
    runCmd(3'd4, 8'h5A, lb);
    check(spuRises == r0 + 1, "R8 request one-shot", spuRises - r0, 1);
    pullupEn = 1'b0;
    arm();
    runCmd(3'd4, 8'h00, lb);
    check(spuRises == r0 + 1, "R8 disabled no pullup", spuRises - r0, 1);
    pullupEn = 1'b1;
    runCmd(3'd4, 8'h00, lb);
    check(spuRises == r0 + 1, "R8 request cleared while disabled", spuRises - r0, 1);
    pullupEn = 1'b0;
  endtask

  task automatic tIgnore;
    int lb, dc;
    // Start during a write-0 slot: a reset request must not take effect.
    @(negedge clk);
    lb = nLow; dc = doneCount;
    cmd = 3'd2; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
    cmd = 3'd0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (doneCount == dc) @(negedge clk);
    repeat (2) @(negedge clk);
    check(doneCyc - startCyc == SLOT + 1, "R10 busy start ignored length", doneCyc - startCyc, SLOT + 1);
    check(nLow - lb == 1 && lens[lb] == 60 * CPU, "R10 busy start ignored pulse", lens[lb], 60 * CPU);
    check(!busy, "R10 idle after done", busy, 0);
    // Unused command codes.
    for (int c = 6; c < 8; c++) begin
      lb = nLow; dc = doneCount;
      @(negedge clk); cmd = 3'(c); start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (30) @(negedge clk);
      check(!busy && doneCount == dc && nLow == lb, "R10 unused code ignored", busy, 0);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    tResetState();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    tBusReset();
    tBitSlots();
    tReadBit();
    tWriteByte(8'hA5);
    tWriteByte(8'h3C);
    tReadByte(8'h3C);
    tReadByte(8'hC1);
    tCoef();
    tPullup();
    tIgnore();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog R10 actual=%0d expected=%0d", 150000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule